// File: doc/BRIEF.md
# Interrupt Flag and Enable Register Pair

This block holds the interrupt bookkeeping of a classic parallel/timer interface adapter. Seven event sources (two handshake lines on each of ports A and B, the serial shifter and two timers) each report with a single-cycle strobe. Each strobe latches a flag bit. A separate enable register picks which flags may raise the single active-high interrupt request. Software reaches both registers through a byte-wide register port. It can also reach the low counter bytes of the two timers and the shifter data byte. Reading those data registers clears the matching flag as a side effect.

The register port is a request/response pair. A request is accepted on any cycle where `bus_valid` is high, because `bus_ready` is tied high and the block never applies back-pressure. An accepted read returns its byte on `rsp_data` with `rsp_valid` high exactly one cycle later. The byte shows the state before that read's own side effect. Writes produce no response.

Register addresses on `bus_addr`: 0 is the flag register, 1 is the enable register, 2 is the timer 1 low byte, 3 is the timer 2 low byte and 4 is the shifter data byte. Addresses 5 to 7 read as zero and ignore writes.

Top module: `via_irq_unit`

## Requirements
- R1: After reset, the flag register reads 0x00, the enable register reads 0x80, the shifter data byte reads 0x00 and `irq` is low.
- R2: A strobe on `event_strobe` bit i sets flag bit i, with this encoding: bit 0 port A line 2, bit 1 port A line 1, bit 2 shifter, bit 3 port B line 2, bit 4 port B line 1, bit 5 timer 2, bit 6 timer 1.
- R3: A flag register read returns the flags in bits 6:0. Bit 7 reads 1 exactly when some flag bit and its matching enable bit are both 1.
- R4: An enable register read returns the enables in bits 6:0 and always returns 1 in bit 7.
- R5: Writing the enable register with data bit 7 = 1 sets each enable bit whose data bit is 1 and leaves the other enable bits unchanged.
- R6: Writing the enable register with data bit 7 = 0 clears each enable bit whose data bit is 1 and leaves the other enable bits unchanged.
- R7: Writing the flag register clears each flag whose data bit in 6:0 is 1. Data bit 7 has no effect.
- R8: Reading address 2 returns `t1_low_count` and clears flag bit 6.
- R9: Reading address 3 returns `t2_low_count` and clears flag bit 5.
- R10: Writing address 4 stores the shifter data byte. Reading address 4 returns that byte and clears flag bit 2.
- R11: `irq` equals the OR over bits 6:0 of flags AND enables. It rises in the cycle right after the setting strobe is sampled, and it falls in the cycle right after the clearing access is accepted.
- R12: When a strobe and a clear (by read side effect or by flag write) hit the same flag in one cycle, the flag ends up set.
- R13: `bus_ready` is always high. `rsp_valid` is high for exactly the one cycle after each accepted read, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register request present |
| bus_ready | output | 1 | Request accepted (always high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_data | output | 8 | Read data |
| event_strobe | input | 7 | Single-cycle event strobes, one per flag bit |
| t1_low_count | input | 8 | Timer 1 low counter byte supplied by the timer |
| t2_low_count | input | 8 | Timer 2 low counter byte supplied by the timer |
| irq | output | 1 | Interrupt request, active high |

## Verification
A wrong flag or enable bit reaches the ports in two ways. It shows on `irq` in the very next cycle whenever the matching bit of the other register is set. It also shows in the next flag or enable read, one cycle after that read is accepted. A read side effect that is missing or lands on the wrong bit leaves a stale flag, and the following flag read exposes it. The same-cycle collision of a strobe and a clear is forced on purpose, because a clear-wins priority would silently lose the event. Only a later flag read can reveal that loss.

// File: rtl/via_irq_pkg.sv
package via_irq_pkg;

  localparam int DATA_W  = 8;
  localparam int NUM_SRC = DATA_W - 1;
  localparam int ADDR_W  = 3;

  // flag bit positions (decoded by software, so they are fixed)
  localparam int BIT_A_LINE2 = 0;
  localparam int BIT_A_LINE1 = 1;
  localparam int BIT_SHIFT   = 2;
  localparam int BIT_B_LINE2 = 3;
  localparam int BIT_B_LINE1 = 4;
  localparam int BIT_TMR2    = 5;
  localparam int BIT_TMR1    = 6;
  localparam int BIT_MODE    = 7;

  // register addresses
  localparam int ADR_FLAGS  = 0;
  localparam int ADR_ENABLE = 1;
  localparam int ADR_T1LO   = 2;
  localparam int ADR_T2LO   = 3;
  localparam int ADR_SHIFT  = 4;

  typedef struct packed {
    logic wr_flags;
    logic wr_enable;
    logic wr_shift;
    logic rd_t1;
    logic rd_t2;
    logic rd_shift;
  } access_t;

endpackage

// File: rtl/via_irq_decode.sv
module via_irq_decode
  import via_irq_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output access_t       acc,
  output logic [DW-2:0] clr_vec
);
  localparam int NS = DW - 1;

  logic is_rd, is_wr;
  assign is_wr = bus_valid &  bus_write;
  assign is_rd = bus_valid & ~bus_write;

  always_comb begin
    acc.wr_flags  = is_wr && (bus_addr == AW'(ADR_FLAGS));
    acc.wr_enable = is_wr && (bus_addr == AW'(ADR_ENABLE));
    acc.wr_shift  = is_wr && (bus_addr == AW'(ADR_SHIFT));
    acc.rd_t1     = is_rd && (bus_addr == AW'(ADR_T1LO));
    acc.rd_t2     = is_rd && (bus_addr == AW'(ADR_T2LO));
    acc.rd_shift  = is_rd && (bus_addr == AW'(ADR_SHIFT));
  end

  always_comb begin
    clr_vec = acc.wr_flags ? bus_wdata[NS-1:0] : '0;
    if (acc.rd_t1)    clr_vec[BIT_TMR1]  = 1'b1;
    if (acc.rd_t2)    clr_vec[BIT_TMR2]  = 1'b1;
    if (acc.rd_shift) clr_vec[BIT_SHIFT] = 1'b1;
  end
endmodule

// File: rtl/via_irq_flags.sv
module via_irq_flags #(
  parameter int NS = via_irq_pkg::NUM_SRC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] set_vec,
  input  logic [NS-1:0] clr_vec,
  output logic [NS-1:0] flags
);
  logic [NS-1:0] flag_q;

  // set has priority over clear so no event is dropped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= set_vec | (flag_q & ~clr_vec);
  end

  assign flags = flag_q;

  for (genvar i = 0; i < NS; i++) begin : g_chk
    assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> flag_q[i]);
    assert_clear_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !set_vec[i]) |=> !flag_q[i]);
    assert_flag_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_vec[i] && flag_q[i]) |=> flag_q[i]);
  end
endmodule

// File: rtl/via_irq_enable.sv
module via_irq_enable #(
  parameter int DW = via_irq_pkg::DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-2:0] enables
);
  localparam int NS = DW - 1;
  logic [NS-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (wr) begin
      if (wdata[DW-1]) en_q <= en_q | wdata[NS-1:0];
      else             en_q <= en_q & ~wdata[NS-1:0];
    end
  end

  assign enables = en_q;

  assert_set_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[DW-1]) |=> ((en_q & $past(wdata[NS-1:0])) == $past(wdata[NS-1:0])));
  assert_clear_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !wdata[DW-1]) |=> ((en_q & $past(wdata[NS-1:0])) == '0));
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(en_q));
endmodule

// File: rtl/via_irq_regport.sv
module via_irq_regport
  import via_irq_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  input  logic          shift_wr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-2:0] flags,
  input  logic [DW-2:0] enables,
  input  logic          pending,
  input  logic [DW-1:0] t1_low,
  input  logic [DW-1:0] t2_low,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  logic [DW-1:0] shift_q;
  logic [DW-1:0] rd_mux;
  logic          rv_q;
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shift_q <= '0;
    else if (shift_wr) shift_q <= wdata;
  end

  always_comb begin
    unique case (rd_addr)
      AW'(ADR_FLAGS):  rd_mux = {pending, flags};
      AW'(ADR_ENABLE): rd_mux = {1'b1, enables};
      AW'(ADR_T1LO):   rd_mux = t1_low;
      AW'(ADR_T2LO):   rd_mux = t2_low;
      AW'(ADR_SHIFT):  rd_mux = shift_q;
      default:         rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rd_q <= '0;
    end else begin
      rv_q <= rd_req;
      if (rd_req) rd_q <= rd_mux;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_data  = rd_q;

  assert_enable_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_addr == AW'(ADR_ENABLE)) |=> rsp_data[DW-1]);
  assert_rsp_follows_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);
  assert_rsp_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid);
endmodule

// File: rtl/via_irq_unit.sv
module via_irq_unit
  import via_irq_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  output logic          bus_ready,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  input  logic [DW-2:0] event_strobe,
  input  logic [DW-1:0] t1_low_count,
  input  logic [DW-1:0] t2_low_count,
  output logic          irq
);
  localparam int NS = DW - 1;

  access_t       acc;
  logic [NS-1:0] clr_vec;
  logic [NS-1:0] flags;
  logic [NS-1:0] enables;
  logic          pending;

  assign bus_ready = 1'b1;

  via_irq_decode #(.DW(DW), .AW(AW)) u_decode (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .acc       (acc),
    .clr_vec   (clr_vec)
  );

  via_irq_flags #(.NS(NS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (event_strobe),
    .clr_vec (clr_vec),
    .flags   (flags)
  );

  via_irq_enable #(.DW(DW)) u_enable (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (acc.wr_enable),
    .wdata   (bus_wdata),
    .enables (enables)
  );

  assign pending = |(flags & enables);
  assign irq     = pending;

  via_irq_regport #(.DW(DW), .AW(AW)) u_regport (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (bus_valid && !bus_write),
    .rd_addr   (bus_addr),
    .shift_wr  (acc.wr_shift),
    .wdata     (bus_wdata),
    .flags     (flags),
    .enables   (enables),
    .pending   (pending),
    .t1_low    (t1_low_count),
    .t2_low    (t2_low_count),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (event_strobe == '0 && !bus_valid) |=> $stable(irq));
  assert_ready_R13: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready);
endmodule

// File: tb/tb_via_irq_unit.sv
module tb_via_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_valid = 1'b0;
  logic       bus_ready;
  logic       bus_write = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       rsp_valid;
  logic [7:0] rsp_data;
  logic [6:0] event_strobe = '0;
  logic [7:0] t1_low_count = 8'h00;
  logic [7:0] t2_low_count = 8'h00;
  logic       irq;

  int tests = 0;
  int fails = 0;
  logic [6:0] m_flags = '0;
  logic [6:0] m_en = '0;

  always #2.5 clk = ~clk;

  via_irq_unit dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .event_strobe(event_strobe),
    .t1_low_count(t1_low_count), .t2_low_count(t2_low_count), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] flag_view();
    return {|(m_flags & m_en), m_flags};
  endfunction

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    check("R13 rsp_valid after read", {7'd0, rsp_valid}, 8'h01);
    d = rsp_data;
  endtask

  task automatic pulse(input logic [6:0] ev);
    @(negedge clk);
    event_strobe = ev;
    @(negedge clk);
    event_strobe = '0;
    m_flags |= ev;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 irq after reset", {7'd0, irq}, 8'h00);
    check("R13 bus_ready", {7'd0, bus_ready}, 8'h01);
    do_read(3'd0, d); check("R1 flags after reset", d, 8'h00);
    do_read(3'd1, d); check("R1 R4 enable after reset", d, 8'h80);
    do_read(3'd4, d); check("R1 shift after reset", d, 8'h00);
    @(negedge clk);
    check("R13 rsp_valid drops", {7'd0, rsp_valid}, 8'h00);
  endtask

  task automatic t_events();
    logic [7:0] d;
    for (int i = 0; i < 7; i++) begin
      pulse(7'(1 << i));
      do_read(3'd0, d);
      check("R2 R3 flag bit set by strobe", d, flag_view());
    end
    check("R11 irq low with no enables", {7'd0, irq}, 8'h00);
    do_write(3'd0, 8'h7F); m_flags = '0;
    do_read(3'd0, d); check("R7 flags cleared", d, 8'h00);
  endtask

  task automatic t_enable();
    logic [7:0] d;
    do_write(3'd1, 8'hC1); m_en |= 7'h41;
    do_read(3'd1, d); check("R5 set mode", d, 8'hC1);
    do_write(3'd1, 8'h96); m_en |= 7'h16;
    do_read(3'd1, d); check("R5 set mode keeps others", d, 8'hD7);
    do_write(3'd1, 8'h01); m_en &= ~7'h01;
    do_read(3'd1, d); check("R6 clear mode", d, 8'hD6);
    do_write(3'd1, 8'h00);
    do_read(3'd1, d); check("R6 clear with zero data no change", d, 8'hD6);
    pulse(7'h01);
    check("R11 irq stays low, bit not enabled", {7'd0, irq}, 8'h00);
    do_read(3'd0, d); check("R3 summary low", d, 8'h01);
    pulse(7'h10);
    check("R11 irq high", {7'd0, irq}, 8'h01);
    do_read(3'd0, d); check("R3 summary high", d, flag_view());
  endtask

  task automatic t_flag_write();
    logic [7:0] d;
    do_write(3'd0, 8'h81); m_flags &= ~7'h01;
    do_read(3'd0, d); check("R7 write clears only bit0", d, flag_view());
    check("R7 bit4 still set", {7'd0, d[4]}, 8'h01);
    do_write(3'd0, 8'h80);
    do_read(3'd0, d); check("R7 data bit7 no effect", d, flag_view());
    do_write(3'd0, 8'h10); m_flags &= ~7'h10;
    check("R11 irq falls after clear", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_read_clear();
    logic [7:0] d;
    t1_low_count = 8'h5A; t2_low_count = 8'hA7;
    pulse(7'h60);
    check("R11 irq from timer1", {7'd0, irq}, 8'h01);
    do_read(3'd2, d); check("R8 timer1 low value", d, 8'h5A);
    m_flags &= ~7'h40;
    check("R8 R11 irq falls after timer1 read", {7'd0, irq}, 8'h00);
    do_read(3'd0, d); check("R8 flag6 cleared", d, flag_view());
    do_read(3'd3, d); check("R9 timer2 low value", d, 8'hA7);
    m_flags &= ~7'h20;
    do_read(3'd0, d); check("R9 flag5 cleared", d, flag_view());
    do_write(3'd4, 8'h3C);
    pulse(7'h04);
    do_read(3'd0, d); check("R2 shifter flag set", d, flag_view());
    do_read(3'd4, d); check("R10 shift data", d, 8'h3C);
    m_flags &= ~7'h04;
    do_read(3'd0, d); check("R10 flag2 cleared", d, flag_view());
    do_read(3'd5, d); check("R10 unmapped reads zero", d, 8'h00);
  endtask

  task automatic t_race();
    logic [7:0] d;
    t1_low_count = 8'h33;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 3'd2; event_strobe = 7'h40;
    @(negedge clk);
    bus_valid = 1'b0; event_strobe = '0;
    check("R12 read returns timer1", rsp_data, 8'h33);
    m_flags |= 7'h40;
    check("R12 irq kept", {7'd0, irq}, 8'h01);
    do_read(3'd0, d); check("R12 set wins over read clear", d, flag_view());
    pulse(7'h08);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h48;
    event_strobe = 7'h08;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; event_strobe = '0;
    m_flags &= ~7'h40;
    do_read(3'd0, d); check("R12 set wins over flag write", d, flag_view());
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_events();
    t_enable();
    t_flag_write();
    t_read_clear();
    t_race();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule